// File: doc/BRIEF.md
# Dual-Clock Message Mailbox Pair

This block carries single 36-bit messages between two unrelated clock domains, next to a data queue but independent of it. It holds two message slots. The forward slot is loaded from side A and unloaded on side B. The return slot is loaded from side B and unloaded on side A. Each slot has an active-low "occupied" flag in the domain of its writer. While that flag is low, the writer may not post another message. The flag goes high again only after the reader on the far side has taken the message.

Side A addresses the slots with a dedicated select input. Side B addresses them by setting its two-bit transfer-size code to both ones. Any other size code belongs to the queue path, and the mailbox ignores it. Posting and taking a message each flip a toggle bit. The far side sees that bit through a chain of synchronizer flops, so no multi-bit value crosses a clock boundary while it is changing. The reader captures a slot only after it has seen that slot's post, which means an early read cannot release a message it never delivered.

Top module: `xdom_mailbox_pair`

## Requirements
- R1: While reset is asserted, both occupied flags are high and both read-data outputs are zero.
- R2: A side-A write (enable high, write high, mailbox select high) with the forward flag high stores the data in the forward slot, and the forward flag is low after that clock edge.
- R3: A side-A mailbox write made while the forward flag is low is ignored, and the slot keeps its earlier message.
- R4: Once a posted forward message has reached side B, a side-B read with size code 2'b11 puts that message on the side-B read data. The forward flag is still low at the next side-A sample point and goes high within 8 side-A cycles.
- R5: A side-B write with size code 2'b11 and the return flag high stores the data in the return slot, and the return flag is low after that clock edge.
- R6: A side-B mailbox write made while the return flag is low is ignored, and the slot keeps its earlier message.
- R7: Once a posted return message has reached side A, a side-A read with mailbox select high puts that message on the side-A read data. The return flag is still low at the next side-B sample point and goes high within 8 side-B cycles.
- R8: Accesses with enable low, side-A mailbox select low, or a side-B size code other than 2'b11 leave both flags and both read-data outputs unchanged.
- R9: A mailbox read made before the reader's domain has seen the matching post leaves the read data unchanged and does not release the writer's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side-A clock |
| clk_b | input | 1 | Side-B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| a_en | input | 1 | Side-A access enable |
| a_wr | input | 1 | Side-A direction: 1 write, 0 read |
| a_mbox | input | 1 | Side-A mailbox select |
| a_wdata | input | 36 | Side-A write data (forward slot) |
| a_rdata | output | 36 | Side-A read data (return slot, registered) |
| a_full1_n | output | 1 | Forward slot occupied flag, active low, side-A domain |
| b_en | input | 1 | Side-B access enable |
| b_wr | input | 1 | Side-B direction: 1 write, 0 read |
| b_size | input | 2 | Side-B size code; 2'b11 selects the mailbox |
| b_wdata | input | 36 | Side-B write data (return slot) |
| b_rdata | output | 36 | Side-B read data (forward slot, registered) |
| b_full2_n | output | 1 | Return slot occupied flag, active low, side-B domain |

## Verification
The assertions check several properties on every edge of both clocks. Both flags are high during reset. An accepted post lowers its flag on the next edge. Read data never changes unless a qualified mailbox read happened. The remaining behaviour depends on how long a toggle takes to cross the synchronizers. This covers a blocked second post keeping the first message, the flag staying low until the clear event has crossed back, and an early read being ignored. The bench shows these in scenarios where the offset between the two clocks fixes exactly which edge each toggle is seen on.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   // Side-B size code that routes an access to the mailbox instead of the queue
   localparam logic [1:0] MBOX_SIZE_CODE = 2'b11;
   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < mbox_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
         $error("mbox_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
// One message slot: posted in the writer clock domain, taken in the reader
// clock domain. Ownership is tracked with two toggle bits.
module mbox_channel #(
   parameter int unsigned W      = 36,
   parameter int unsigned STAGES = 2
) (
   input  logic         wclk,
   input  logic         rclk,
   input  logic         rst_n,
   input  logic         post,
   input  logic [W-1:0] post_data,
   output logic         occ_n,
   input  logic         take,
   output logic [W-1:0] take_data
);
   logic [W-1:0] slot_q;
   logic         post_tog;
   logic         take_tog;
   logic         post_tog_rs;
   logic         take_tog_ws;
   logic         visible;

   generate
      if (W < 1) begin : g_bad_width
         $error("mbox_channel: W must be positive");
      end
   endgenerate

   // writer domain: slot is free when every post has been answered by a take
   assign occ_n = (post_tog == take_tog_ws);

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q   <= '0;
         post_tog <= 1'b0;
      end else if (post && occ_n) begin
         slot_q   <= post_data;
         post_tog <= ~post_tog;
      end
   end

   mbox_sync #(.STAGES(STAGES)) u_post_sync (
      .clk(rclk), .rst_n(rst_n), .d(post_tog), .q(post_tog_rs)
   );

   // reader domain: a take only counts once the post has been seen here,
   // so the slot content is stable when captured and no message is dropped
   assign visible = (post_tog_rs != take_tog);

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         take_data <= '0;
         take_tog  <= 1'b0;
      end else if (take && visible) begin
         take_data <= slot_q;
         take_tog  <= ~take_tog;
      end
   end

   mbox_sync #(.STAGES(STAGES)) u_take_sync (
      .clk(wclk), .rst_n(rst_n), .d(take_tog), .q(take_tog_ws)
   );
endmodule

// File: rtl/xdom_mailbox_pair.sv
module xdom_mailbox_pair #(
   parameter int unsigned W           = 36,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk_a,
   input  logic         clk_b,
   input  logic         rst_n,
   input  logic         a_en,
   input  logic         a_wr,
   input  logic         a_mbox,
   input  logic [W-1:0] a_wdata,
   output logic [W-1:0] a_rdata,
   output logic         a_full1_n,
   input  logic         b_en,
   input  logic         b_wr,
   input  logic [1:0]   b_size,
   input  logic [W-1:0] b_wdata,
   output logic [W-1:0] b_rdata,
   output logic         b_full2_n
);
   import mbox_pkg::*;

   logic a_sel, b_sel;

   assign a_sel = a_en && a_mbox;
   assign b_sel = b_en && (b_size == MBOX_SIZE_CODE);

   // forward slot: A posts, B takes
   mbox_channel #(.W(W), .STAGES(SYNC_STAGES)) u_fwd (
      .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
      .post(a_sel && a_wr), .post_data(a_wdata), .occ_n(a_full1_n),
      .take(b_sel && !b_wr), .take_data(b_rdata)
   );

   // return slot: B posts, A takes
   mbox_channel #(.W(W), .STAGES(SYNC_STAGES)) u_ret (
      .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
      .post(b_sel && b_wr), .post_data(b_wdata), .occ_n(b_full2_n),
      .take(a_sel && !a_wr), .take_data(a_rdata)
   );
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
   parameter int unsigned W = 36
) (
   input logic         clk_a,
   input logic         clk_b,
   input logic         rst_n,
   input logic         a_en,
   input logic         a_wr,
   input logic         a_mbox,
   input logic [W-1:0] a_wdata,
   input logic [W-1:0] a_rdata,
   input logic         a_full1_n,
   input logic         b_en,
   input logic         b_wr,
   input logic [1:0]   b_size,
   input logic [W-1:0] b_wdata,
   input logic [W-1:0] b_rdata,
   input logic         b_full2_n
);
   logic a_take, b_take;
   assign a_take = a_en && a_mbox && !a_wr;
   assign b_take = b_en && (b_size == 2'b11) && !b_wr;

   assert_reset_fwd_flag_R1: assert property (@(posedge clk_a)
      !rst_n |-> a_full1_n);
   assert_reset_ret_flag_R1: assert property (@(posedge clk_b)
      !rst_n |-> b_full2_n);

   assert_post_marks_fwd_R2: assert property (@(posedge clk_a) disable iff (!rst_n)
      (a_en && a_wr && a_mbox && a_full1_n) |=> !a_full1_n);
   assert_post_marks_ret_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
      (b_en && b_wr && b_size == 2'b11 && b_full2_n) |=> !b_full2_n);

   assert_a_rdata_quiet_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
      !a_take |=> $stable(a_rdata));
   assert_b_rdata_quiet_R8: assert property (@(posedge clk_b) disable iff (!rst_n)
      !b_take |=> $stable(b_rdata));

   // a flag can only fall because of a post on its own side (R2, R5)
   assert_fwd_fall_cause_R2: assert property (@(posedge clk_a) disable iff (!rst_n)
      (a_full1_n && !(a_en && a_wr && a_mbox)) |=> a_full1_n);
   assert_ret_fall_cause_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
      (b_full2_n && !(b_en && b_wr && b_size == 2'b11)) |=> b_full2_n);
endmodule

bind xdom_mailbox_pair mbox_chk #(.W(W)) u_chk (.*);

// File: tb/sim_xdom_mailbox_pair.sv
module sim_xdom_mailbox_pair;
   localparam int W = 36;

   logic clk_a = 1'b0;
   logic clk_b = 1'b0;
   logic rst_n = 1'b0;
   logic a_en = 0, a_wr = 0, a_mbox = 0;
   logic [W-1:0] a_wdata = '0;
   logic [W-1:0] a_rdata;
   logic a_full1_n;
   logic b_en = 0, b_wr = 0;
   logic [1:0] b_size = 2'b00;
   logic [W-1:0] b_wdata = '0;
   logic [W-1:0] b_rdata;
   logic b_full2_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk_a = ~clk_a;
   initial begin
      #3;
      forever #5 clk_b = ~clk_b;
   end

   xdom_mailbox_pair #(.W(W), .SYNC_STAGES(2)) u0 (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic a_op(input logic en, input logic wr, input logic mb, input logic [W-1:0] d);
      @(negedge clk_a);
      a_en = en; a_wr = wr; a_mbox = mb; a_wdata = d;
      @(negedge clk_a);
      a_en = 0; a_wr = 0; a_mbox = 0;
   endtask

   task automatic b_op(input logic en, input logic wr, input logic [1:0] sz, input logic [W-1:0] d);
      @(negedge clk_b);
      b_en = en; b_wr = wr; b_size = sz; b_wdata = d;
      @(negedge clk_b);
      b_en = 0; b_wr = 0; b_size = 2'b00;
   endtask

   task automatic wait_a(input int n);
      for (int k = 0; k < n; k++) @(negedge clk_a);
   endtask

   task automatic wait_b(input int n);
      for (int k = 0; k < n; k++) @(negedge clk_b);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] prev_b, prev_a, d1, d2, junk;
      prev_a = '0;
      prev_b = '0;
      wait_a(3);
      // R1 reset state
      chk("R1 fwd flag", 64'(a_full1_n), 64'd1);
      chk("R1 ret flag", 64'(b_full2_n), 64'd1);
      chk("R1 a_rdata", 64'(a_rdata), 64'd0);
      chk("R1 b_rdata", 64'(b_rdata), 64'd0);
      rst_n = 1'b1;
      wait_a(2);

      for (int i = 0; i < 6; i++) begin
         d1   = {4'(i + 1), 32'hA5A5_0000 + 32'(i) * 32'h0001_1111};
         d2   = ~d1 ^ 36'(i * 7);
         junk = d1 ^ 36'hF_0F0F_0F0F;

         // R8: non-mailbox and disabled accesses
         a_op(1, 1, 0, junk);
         chk("R8 A write mbox=0 flag", 64'(a_full1_n), 64'd1);
         a_op(0, 1, 1, junk);
         chk("R8 A write en=0 flag", 64'(a_full1_n), 64'd1);
         b_op(1, 1, 2'(i % 3), junk);
         chk("R8 B write size!=11 flag", 64'(b_full2_n), 64'd1);

         // forward direction
         a_op(1, 1, 1, d1);
         chk("R2 fwd flag low after post", 64'(a_full1_n), 64'd0);
         b_op(1, 0, 2'b11, '0);   // too early: post not yet seen on side B
         chk("R9 early B read data", 64'(b_rdata), 64'(prev_b));
         a_op(1, 1, 1, junk);     // blocked post
         chk("R3 fwd flag still low", 64'(a_full1_n), 64'd0);
         wait_b(4);
         b_op(1, 0, 2'(i % 3), '0);
         chk("R8 B read size!=11 data", 64'(b_rdata), 64'(prev_b));
         chk("R9 fwd flag held after early read", 64'(a_full1_n), 64'd0);
         b_op(1, 0, 2'b11, '0);
         chk("R3 R4 B read returns first message", 64'(b_rdata), 64'(d1));
         @(negedge clk_a);
         chk("R4 fwd flag low until clear synced", 64'(a_full1_n), 64'd0);
         for (int k = 0; k < 8 && !a_full1_n; k++) @(negedge clk_a);
         chk("R4 fwd flag released", 64'(a_full1_n), 64'd1);
         prev_b = d1;

         // return direction
         b_op(1, 1, 2'b11, d2);
         chk("R5 ret flag low after post", 64'(b_full2_n), 64'd0);
         a_op(1, 0, 1, '0);       // too early
         chk("R9 early A read data", 64'(a_rdata), 64'(prev_a));
         b_op(1, 1, 2'b11, junk); // blocked post
         chk("R6 ret flag still low", 64'(b_full2_n), 64'd0);
         wait_a(4);
         a_op(1, 0, 0, '0);
         chk("R8 A read mbox=0 data", 64'(a_rdata), 64'(prev_a));
         chk("R9 ret flag held after early read", 64'(b_full2_n), 64'd0);
         a_op(1, 0, 1, '0);
         chk("R6 R7 A read returns first message", 64'(a_rdata), 64'(d2));
         @(negedge clk_b);
         chk("R7 ret flag low until clear synced", 64'(b_full2_n), 64'd0);
         for (int k = 0; k < 8 && !b_full2_n; k++) @(negedge clk_b);
         chk("R7 ret flag released", 64'(b_full2_n), 64'd1);
         prev_a = d2;
         wait_a(2);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule